// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a small single-port synchronous memory that accepts a read or a write command on every clock edge with no idle cycles between them, whatever the mix. Address, chip enables, write enable, byte write enables and the advance/load control are all captured on the rising edge. The write data for a command is taken from the data bus after the same delay that a read needs to present its data, so both kinds of command occupy the data bus in the same relative slot. A static mode input picks the pipelined variant, with a two-edge delay, or the flow-through variant, with a one-edge delay.

A command can start a new access at a given address, or it can advance a two-bit burst counter. An advance repeats the operation type of the burst and uses the next address in linear or interleaved order, chosen by a static order input. The read path is a qualified output with a drive-enable flag rather than a handshake: the latency is fixed, so there is no back-pressure and the requester must accept read data in its slot. An asynchronous output enable can force the drive flag off at any time. A sleep input stops new commands from being accepted while the stored words are kept.

The data bus is split into an input half and an output half with a drive-enable flag. Bytes are 9 bits wide.

Top module: `nbt_sram`

## Requirements
- R1: After reset every word of the array reads as zero and `dout_oe` is low. A word written with all byte enables active is read back unchanged.
- R2: With `flow_mode`=0, a read command sampled at edge k presents its word on `dout` with `dout_oe` high from edge k+1 until edge k+2. The write data for a write command sampled at edge k is taken from `din` at edge k+2.
- R3: With `flow_mode`=1, a read command sampled at edge k presents its word from edge k until edge k+1. The write data for a write command sampled at edge k is taken from `din` at edge k+1.
- R4: `bw_n[i]` low writes bits 9*i+8 down to 9*i and leaves the other bytes as they were. The byte write enables are sampled at the same edge as their command.
- R5: A write command with every `bw_n` bit high changes no word, and `dout_oe` stays low in its data slot.
- R6: A new-address command (`adv`=0) is accepted only when `cs_a`=1, `cs_b`=1 and `cs_c_n`=0. Otherwise it is a deselect: it writes nothing, nothing is driven in its slot, and it ends any burst.
- R7: `adv`=0 loads the address from `addr`. `adv`=1 repeats the operation type of the burst and ignores the chip enables and `wr_n`, but it samples `bw_n`. An advance issued when no burst is active does nothing.
- R8: On the n-th advance of a burst, the upper address bits keep their start value. The low two bits are (start+n) mod 4 when `ilv_order`=0 and start XOR n when `ilv_order`=1.
- R9: Any mix of reads and writes can be issued on consecutive edges. A read issued right after a write to the same address returns the newly written word.
- R10: `dout_oe` is low in the data slot of every write and every deselect. `oe_n`=1 forces `dout_oe` low at once.
- R11: After `sleep`=1 is sampled at edge k, commands from edge k+2 on are ignored. After `sleep`=0 is sampled at edge f, commands stay ignored through edge f+1+WAKE_CYC. Stored words are kept throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_mode | input | 1 | Static: 1 selects flow-through, 0 selects pipelined |
| ilv_order | input | 1 | Static: 1 selects interleaved burst order, 0 selects linear |
| cs_a | input | 1 | Chip enable, active high |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 for write, 1 for read on a new-address command |
| bw_n | input | NB | Active-low byte write enables |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| addr | input | AW | Word address |
| din | input | NB*9 | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep request |
| dout | output | NB*9 | Read data |
| dout_oe | output | 1 | Read data is being driven |

## Verification
The hardest case to reach from the ports is in pipelined mode. A write commits at the same edge at which the following read captures its word into the output register, so the read must be served from the write data in flight rather than from the array. The stimulus reaches this case with alternating write and read commands to the same address on consecutive edges, including partial byte writes, and with pairs that hit different addresses. Each sweep is run in both modes and both burst orders. The expected words come from an ordered model of the command list that computes the burst addresses arithmetically.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  localparam int BYTE_W = 9;

  // low two address bits on the n-th beat of a burst
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/nbt_sleep_ctl.sv
module nbt_sleep_ctl #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic asleep
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [1:0]    pipe;
  logic [CW-1:0] wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
      wake <= '0;
    end else begin
      pipe <= {pipe[0], sleep};
      if (pipe[1] && !pipe[0]) wake <= CW'(WAKE_CYC);
      else if (wake != '0)     wake <= wake - 1'b1;
    end
  end

  assign asleep = pipe[1] | (wake != '0);
endmodule

// File: rtl/nbt_cmd_dec.sv
module nbt_cmd_dec #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          en_ok,
  input  logic          wr_n,
  input  logic          ilv,
  input  logic          asleep,
  input  logic [AW-1:0] addr,
  output logic          take,
  output logic          take_wr,
  output logic [AW-1:0] acc_addr
);
  import nbt_sram_pkg::*;

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          b_vld;
  logic          b_wr;
  logic [1:0]    cnt_nxt;

  assign cnt_nxt = cnt + 2'd1;

  always_comb begin
    if (!adv) begin
      take     = en_ok & ~asleep;
      take_wr  = ~wr_n;
      acc_addr = addr;
    end else begin
      take     = b_vld & ~asleep;
      take_wr  = b_wr;
      acc_addr = {base[AW-1:2], burst_low(base[1:0], cnt_nxt, ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      cnt   <= '0;
      b_vld <= 1'b0;
      b_wr  <= 1'b0;
    end else if (asleep) begin
      b_vld <= 1'b0;
    end else if (!adv) begin
      base  <= addr;
      cnt   <= '0;
      b_vld <= en_ok;
      b_wr  <= ~wr_n;
    end else if (b_vld) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int AW = 4,
  parameter int NB = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [NB-1:0]                wmask,
  input  logic [AW-1:0]                waddr,
  input  logic [NB*nbt_sram_pkg::BYTE_W-1:0] wdata,
  input  logic [AW-1:0]                raddr,
  output logic [NB*nbt_sram_pkg::BYTE_W-1:0] rdata
);
  import nbt_sram_pkg::*;
  localparam int DW    = NB * BYTE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      for (int b = 0; b < NB; b++)
        if (wmask[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int AW       = 4,
  parameter int NB       = 2,
  parameter int WAKE_CYC = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flow_mode,
  input  logic                              ilv_order,
  input  logic                              cs_a,
  input  logic                              cs_b,
  input  logic                              cs_c_n,
  input  logic                              wr_n,
  input  logic [NB-1:0]                     bw_n,
  input  logic                              adv,
  input  logic [AW-1:0]                     addr,
  input  logic [NB*nbt_sram_pkg::BYTE_W-1:0] din,
  input  logic                              oe_n,
  input  logic                              sleep,
  output logic [NB*nbt_sram_pkg::BYTE_W-1:0] dout,
  output logic                              dout_oe
);
  import nbt_sram_pkg::*;
  localparam int DW = NB * BYTE_W;

  logic          en_ok, asleep, take, take_wr;
  logic [AW-1:0] acc_addr;

  assign en_ok = cs_a & cs_b & ~cs_c_n;

  nbt_sleep_ctl #(.WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .asleep(asleep)
  );

  nbt_cmd_dec #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .adv(adv), .en_ok(en_ok), .wr_n(wr_n),
    .ilv(ilv_order), .asleep(asleep), .addr(addr),
    .take(take), .take_wr(take_wr), .acc_addr(acc_addr)
  );

  // command stages: s1 holds the command of the last edge, s2 the one before
  logic          s1_vld, s1_wr, s2_vld, s2_wr;
  logic [NB-1:0] s1_mask, s2_mask;
  logic [AW-1:0] s1_addr, s2_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_wr <= 1'b0; s1_mask <= '0; s1_addr <= '0;
      s2_vld <= 1'b0; s2_wr <= 1'b0; s2_mask <= '0; s2_addr <= '0;
    end else begin
      s1_vld <= take;   s1_wr <= take_wr; s1_mask <= ~bw_n;  s1_addr <= acc_addr;
      s2_vld <= s1_vld; s2_wr <= s1_wr;   s2_mask <= s1_mask; s2_addr <= s1_addr;
    end
  end

  // write port: data arrives one edge (flow) or two edges (pipelined) late
  logic          w_en;
  logic [NB-1:0] w_mask;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] rdata;

  assign w_en   = flow_mode ? (s1_vld & s1_wr) : (s2_vld & s2_wr);
  assign w_mask = flow_mode ? s1_mask : s2_mask;
  assign w_addr = flow_mode ? s1_addr : s2_addr;

  nbt_array #(.AW(AW), .NB(NB)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(w_en), .wmask(w_mask), .waddr(w_addr),
    .wdata(din), .raddr(s1_addr), .rdata(rdata)
  );

  // pipelined output register, bypassing a write that commits at the same edge
  logic          fwd_hit;
  logic [DW-1:0] fwd, dq;
  logic          rd_q;

  assign fwd_hit = ~flow_mode & s2_vld & s2_wr & (s2_addr == s1_addr);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign fwd[b*BYTE_W +: BYTE_W] = (fwd_hit && s2_mask[b]) ?
                                     din[b*BYTE_W +: BYTE_W] : rdata[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq   <= '0;
      rd_q <= 1'b0;
    end else begin
      dq   <= fwd;
      rd_q <= s1_vld & ~s1_wr;
    end
  end

  assign dout    = flow_mode ? rdata : dq;
  assign dout_oe = ~oe_n & (flow_mode ? (s1_vld & ~s1_wr) : rd_q);
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flow_mode,
  input logic          oe_n,
  input logic          adv,
  input logic          dout_oe,
  input logic          s1_vld,
  input logic          s1_wr,
  input logic [AW-1:2] s1_hi,
  input logic          asleep
);
  p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && s1_vld && !s1_wr) |=> (oe_n || dout_oe));

  p_flow_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && s1_vld && !s1_wr && !oe_n) |-> dout_oe);

  p_pipe_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && s1_vld && s1_wr) |=> !dout_oe);

  p_burst_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adv) && s1_vld) |-> (s1_hi == $past(s1_hi)));

  p_sleep_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(asleep) |-> !s1_vld);
endmodule

bind nbt_sram nbt_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .oe_n(oe_n), .adv(adv),
  .dout_oe(dout_oe), .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_hi(s1_addr[AW-1:2]),
  .asleep(asleep)
);

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;
  localparam int AW = 4, NB = 2, DW = 18, DEPTH = 16, WAKE = 4, NMAX = 160;
  localparam logic [2:0] GOOD = 3'b110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flow_mode = 1'b0, ilv_order = 1'b0;
  logic cs_a = 1'b0, cs_b = 1'b0, cs_c_n = 1'b1, wr_n = 1'b1, adv = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dout;
  logic dout_oe;

  always #10 clk = ~clk;

  nbt_sram #(.AW(AW), .NB(NB), .WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .ilv_order(ilv_order),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n), .wr_n(wr_n), .bw_n(bw_n),
    .adv(adv), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0, failures = 0;

  // command list
  bit            c_adv [NMAX], c_wr [NMAX], c_oen [NMAX], c_slp [NMAX], c_ign [NMAX];
  logic [2:0]    c_en  [NMAX];
  logic [NB-1:0] c_bwn [NMAX];
  int            c_addr[NMAX];
  logic [DW-1:0] c_din [NMAX];
  string         c_tag [NMAX];
  bit            e_rd  [NMAX];
  logic [DW-1:0] e_dat [NMAX];
  int n_cmd = 0;

  // reference model state
  logic [DW-1:0] mm [DEPTH];
  int m_base, m_cnt;
  bit m_bv, m_bw;

  function automatic logic [DW-1:0] dgen(input int s);
    return DW'(s * 40503 + 341);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit a, input bit w, input logic [2:0] en,
                      input logic [NB-1:0] bwn, input int ad, input logic [DW-1:0] d,
                      input bit oen, input bit slp, input bit ign, input string tag);
    c_adv[n_cmd] = a; c_wr[n_cmd] = w; c_en[n_cmd] = en; c_bwn[n_cmd] = bwn;
    c_addr[n_cmd] = ad; c_din[n_cmd] = d; c_oen[n_cmd] = oen; c_slp[n_cmd] = slp;
    c_ign[n_cmd] = ign; c_tag[n_cmd] = tag;
    n_cmd++;
  endtask

  task automatic wl(input int a, input logic [DW-1:0] d, input string t);
    push(0, 1, GOOD, '0, a, d, 0, 0, 0, t);
  endtask
  task automatic rl(input int a, input string t);
    push(0, 0, GOOD, '1, a, '0, 0, 0, 0, t);
  endtask
  task automatic aw(input logic [DW-1:0] d, input string t);
    push(1, 0, 3'b000, '0, 0, d, 0, 0, 0, t);
  endtask
  task automatic ar(input string t);
    push(1, 1, 3'b000, '1, 0, '0, 0, 0, 0, t);
  endtask
  task automatic ds(input int a, input string t);
    push(0, 1, 3'b000, '0, a, '0, 0, 0, 0, t);
  endtask

  task automatic build_expect();
    for (int i = 0; i < n_cmd; i++) begin
      bit v, w;
      int a, lo;
      if (c_ign[i]) begin
        v = 0; w = 0; a = 0; m_bv = 0;
      end else if (!c_adv[i]) begin
        v = (c_en[i] == GOOD); w = c_wr[i]; a = c_addr[i];
        m_base = a; m_cnt = 0; m_bv = v; m_bw = w;
      end else begin
        v = m_bv; w = m_bw;
        if (m_bv) m_cnt = (m_cnt + 1) % 4;
        lo = ilv_order ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        a = (m_base & ~3) | lo;
      end
      if (v && w)
        for (int b = 0; b < NB; b++)
          if (!c_bwn[i][b]) mm[a][b*9 +: 9] = c_din[i][b*9 +: 9];
      e_rd[i]  = v && !w;
      e_dat[i] = mm[a];
    end
  endtask

  task automatic run();
    int L;
    L = flow_mode ? 1 : 2;
    build_expect();
    for (int j = 0; j < n_cmd + L; j++) begin
      @(negedge clk);
      oe_n = (j >= L) ? c_oen[j-L] : 1'b0;
      #1;
      if (j >= L) begin
        int i;
        bit exp_oe;
        i = j - L;
        exp_oe = e_rd[i] && !c_oen[i];
        chk(dout_oe == exp_oe, c_tag[i], "dout_oe", DW'(dout_oe), DW'(exp_oe));
        if (exp_oe) chk(dout == e_dat[i], c_tag[i], "dout", dout, e_dat[i]);
        din = c_din[i];
      end else din = '0;
      if (j < n_cmd) begin
        adv = c_adv[j]; wr_n = ~c_wr[j]; {cs_a, cs_b, cs_c_n} = c_en[j];
        bw_n = c_bwn[j]; addr = AW'(c_addr[j]); sleep = c_slp[j];
      end else begin
        adv = 1'b0; wr_n = 1'b1; {cs_a, cs_b, cs_c_n} = 3'b000; bw_n = '1; sleep = 1'b0;
      end
    end
    oe_n = 1'b0;
    n_cmd = 0;
  endtask

  task automatic do_cfg(input bit fm, input bit ilv);
    string rt;
    rt = fm ? "R3" : "R2";
    @(negedge clk);
    rst_n = 1'b0; flow_mode = fm; ilv_order = ilv;
    adv = 1'b0; {cs_a, cs_b, cs_c_n} = 3'b000; sleep = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    m_bv = 0; m_base = 0; m_cnt = 0; m_bw = 0;
    #1 chk(dout_oe == 1'b0, "R1", "oe after reset", DW'(dout_oe), '0);
    // R1 reset contents, then full fill and read back (latency R2 or R3)
    rl(3, "R1"); rl(12, "R1");
    for (int a = 0; a < DEPTH; a++) wl(a, dgen(a + 17 * fm + 5 * ilv), "R1");
    for (int a = 0; a < DEPTH; a++) rl(a, rt);
    run();
    // R4 byte writes
    push(0, 1, GOOD, 2'b10, 5, dgen(901), 0, 0, 0, "R4");
    push(0, 1, GOOD, 2'b01, 6, dgen(902), 0, 0, 0, "R4");
    rl(5, "R4"); rl(6, "R4");
    // R5 write abort
    push(0, 1, GOOD, 2'b11, 7, dgen(903), 0, 0, 0, "R5");
    rl(7, "R5");
    // R6 each enable false
    push(0, 1, 3'b010, '0, 8, dgen(904), 0, 0, 0, "R6");
    push(0, 1, 3'b100, '0, 8, dgen(905), 0, 0, 0, "R6");
    push(0, 1, 3'b111, '0, 8, dgen(906), 0, 0, 0, "R6");
    push(0, 0, 3'b111, '1, 8, '0, 0, 0, 0, "R6");
    rl(8, "R6");
    run();
    // R7 and R8 bursts, several start points
    wl(13, dgen(1001), "R7"); aw(dgen(1002), "R8"); aw(dgen(1003), "R8"); aw(dgen(1004), "R8");
    rl(12, "R8"); ar("R8"); ar("R8"); ar("R8");
    rl(14, "R8"); ar("R8"); ar("R8"); ar("R8"); ar("R8");
    wl(3, dgen(1010), "R8"); aw(dgen(1011), "R8");
    rl(0, "R8"); ar("R8"); ar("R8"); ar("R8");
    ds(9, "R7"); aw(dgen(1020), "R7"); aw(dgen(1021), "R7");
    rl(9, "R7"); rl(10, "R7"); rl(11, "R7");
    run();
    // R9 back-to-back mixes
    wl(2, dgen(1100), "R9"); rl(2, "R9"); wl(2, dgen(1101), "R9"); rl(2, "R9");
    push(0, 1, GOOD, 2'b01, 2, dgen(1102), 0, 0, 0, "R9"); rl(2, "R9");
    wl(4, dgen(1103), "R9"); rl(5, "R9"); rl(4, "R9"); wl(5, dgen(1104), "R9");
    wl(6, dgen(1105), "R9"); rl(5, "R9"); rl(6, "R9");
    run();
    // R10 output enable forced off, write slot quiet
    push(0, 0, GOOD, '1, 2, '0, 1, 0, 0, "R10");
    wl(1, dgen(1200), "R10");
    rl(1, "R10");
    run();
    // R11 sleep window
    for (int k = 0; k < 3; k++) push(0, 1, 3'b000, '0, 0, '0, 0, 1, 0, "R11");
    for (int a = 0; a < 4; a++) push(0, 1, GOOD, '0, a, dgen(1300 + a), 0, 1, 1, "R11");
    push(0, 0, GOOD, '1, 1, '0, 0, 1, 1, "R11");
    for (int k = 0; k < WAKE + 4; k++) ds(0, "R11");
    for (int a = 0; a < 4; a++) rl(a, "R11");
    run();
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_cfg(0, 0);
    do_cfg(0, 1);
    do_cfg(1, 0);
    do_cfg(1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule